// File: doc/BRIEF.md
# SD Command Line Engine

This block is the command-path half of an SD/MMC host. Software programs a command index and a 32-bit argument, then writes a control word whose start bit launches one operation. The engine shifts out a 48-bit command frame with its CRC7 on the card's command line. Depending on the 4-bit operation code, it then listens for a short (48-bit) or long (136-bit) reply, verifies the reply's CRC7 and unpacks it into five 32-bit reply words. For one operation code it also waits for the card to release its busy signal on data line 0. A separate operation only runs the card clock for card power-up.

Each cycle of `clk` is one card-clock bit time. The block raises `sd_clk_en` whenever the card clock must run, and a divider outside the block turns this into the pin clock. Completion is signalled by a sticky done flag that software clears by writing 1, and that flag can be routed to `irq`. Separate sticky flags report a missing reply, a reply checksum error and a busy-wait timeout.

Top module: `sd_cmd_engine`

## Requirements
- R1: Registers are word-addressed at byte offsets 0x00 (general enable, plain storage), 0x04 (control), 0x08 (status), 0x0C (command index, bits [5:0]), 0x10 (argument) and 0x14, 0x18, 0x1C, 0x20, 0x24 (reply words 0 to 4). All registers read 0 after reset, and the enable, index and argument registers read back what was written.
- R2: A started command drives `cmd_oe` high for exactly 48 cycles. During those cycles `cmd_out` carries, most significant bit first: a 0, a 1, the 6-bit index, the 32-bit argument, the CRC7 (generator x^7+x^3+1, zero seed) of those first 40 bits, and a closing 1.
- R3: Operation code 0 (control bits [3:0]) expects no reply. The done flag is set in the cycle after the last frame bit, and no error flag is set.
- R4: Operation codes 1, 4 and 5 take a 48-bit reply. Reply word 0 receives the last 32 received bits, so its bits [7:0] hold the checksum byte. Reply word 1 bits [15:0] receive the first 16 received bits. The 32-bit card status therefore reads as {word1[7:0], word0[31:8]}.
- R5: Operation code 2 takes a 136-bit reply. Words 0 to 3 receive its bits 31:0, 63:32, 95:64 and 127:96, word 4 bits [7:0] receive its first 8 bits, and the CRC7 covers reply bits 127:8.
- R6: When the received CRC7 differs from the one the engine computes, status bit 0 is set together with the done flag.
- R7: After the frame the engine samples `cmd_in` for 64 cycles. A low level in that window starts the reply. If no low level arrives, status bit 4 and the done flag are set.
- R8: Operation code 3 takes a 48-bit reply and then waits until `dat0_in` is high before it sets the done flag.
- R9: When control bit 31 is set, the busy wait of code 3 is cut off after (control bits [30:24]) x 16 cycles. Status bit 15 and the done flag are then set. Starting an operation clears status bits 0, 4 and 15.
- R10: Operation code 8 raises `sd_clk_en` for (control bits [11:8]) x 16 cycles without driving `cmd_oe`, then sets the done flag.
- R11: The done flag is status bit 5. Writing 1 to it clears it and writing 0 leaves it. Status bit 6 is a read/write enable, and `irq` is high while both bits are 1.
- R12: Control bit 7 starts an operation and reads 1 while one is running. Control writes during an operation are ignored. Control bits [23:16] keep their written value across operations.
- R13: A start with an operation code outside {0,1,2,3,4,5,8} is ignored: the clock enable stays low and no done flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| cmd_in | input | 1 | Command line input from card |
| dat0_in | input | 1 | Data line 0 input, low while the card is busy |
| sd_clk_en | output | 1 | Card clock must run this cycle |
| irq | output | 1 | Done interrupt |

## Verification
On every cycle the assertions check the frame shape: a leading 0 then a 1, exactly 48 driven cycles, and the clock enable running whenever the line is driven. They also check that the done flag only rises as an operation ends, that the delay field changes only on a control write, and that the no-reply and checksum flags never appear together. Only the bench scenarios can show the rest. These are the CRC7 value and bit order of transmitted frames, the packing of short and long replies into the reply words, the exact edges of the 64-cycle reply window, the busy wait and its timeout, the length of the power-up clock burst, write-one-to-clear behaviour, and that illegal codes and mid-operation control writes have no effect.

// File: rtl/sd_cmd_engine.sv
`timescale 1ns/1ps
module sd_cmd_engine #(
  parameter int RSP_WINDOW = 64,
  parameter int INIT_SHIFT = 4,
  parameter int TOUT_SHIFT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        cmd_out,
  output logic        cmd_oe,
  input  logic        cmd_in,
  input  logic        dat0_in,
  output logic        sd_clk_en,
  output logic        irq
);

  localparam int WIN_W  = $clog2(RSP_WINDOW) + 1;
  localparam int TOUT_W = 7 + TOUT_SHIFT;
  localparam int INIT_W = 4 + INIT_SHIFT;
  localparam int MAX_A  = (WIN_W > TOUT_W) ? WIN_W : TOUT_W;
  localparam int CNT_W  = ((MAX_A > INIT_W) ? MAX_A : INIT_W) + 1;

  typedef enum logic [2:0] {S_IDLE, S_TX, S_WAIT, S_RX, S_BUSY, S_INIT} state_t;

  state_t             st_q;
  logic [31:0]        en_q, ctl_q, arg_q;
  logic [5:0]         idx_q;
  logic [31:0]        rsp_q [5];
  logic               te_q, ie_q, crc_err_q, nrsp_q, tout_q;
  logic [7:0]         pos_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [6:0]         crc_q;
  logic [39:0]        sh_q;
  logic [135:0]       rx_q;

  function automatic logic [6:0] crc_step(input logic [6:0] c, input logic b);
    return {c[5:0], 1'b0} ^ ((c[6] ^ b) ? 7'h09 : 7'h00);
  endfunction

  logic [3:0] mode;
  logic       long_rsp, busy, wr_ctl, start_ok, mode_ok, crc_feed;
  logic [7:0] last_idx, crc_lo, crc_hi, rx_idx;
  logic [135:0] rx_next;
  logic [CNT_W-1:0] init_lim, tout_lim;

  assign mode      = ctl_q[3:0];
  assign long_rsp  = (mode == 4'd2);
  assign last_idx  = long_rsp ? 8'd135 : 8'd47;
  assign crc_lo    = long_rsp ? 8'd8   : 8'd0;
  assign crc_hi    = long_rsp ? 8'd128 : 8'd40;
  assign busy      = (st_q != S_IDLE);
  assign wr_ctl    = reg_we && (reg_addr == 6'h04);
  assign mode_ok   = (reg_wdata[3:0] <= 4'd5) || (reg_wdata[3:0] == 4'd8);
  assign start_ok  = wr_ctl && !busy && reg_wdata[7] && mode_ok;
  assign rx_idx    = (st_q == S_WAIT) ? 8'd0 : pos_q;
  assign crc_feed  = (rx_idx >= crc_lo) && (rx_idx < crc_hi);
  assign rx_next   = {rx_q[134:0], cmd_in};
  assign init_lim  = CNT_W'(ctl_q[11:8]) << INIT_SHIFT;
  assign tout_lim  = CNT_W'(ctl_q[30:24]) << TOUT_SHIFT;

  assign cmd_oe    = (st_q == S_TX);
  assign cmd_out   = !cmd_oe ? 1'b1 :
                     (pos_q < 8'd40) ? sh_q[39] :
                     (pos_q < 8'd47) ? crc_q[6] : 1'b1;
  assign sd_clk_en = busy;
  assign irq       = te_q & ie_q;

  always_comb begin
    case (reg_addr)
      6'h00:   reg_rdata = en_q;
      6'h04:   reg_rdata = {ctl_q[31:8], busy, ctl_q[6:0]};
      6'h08: begin
        reg_rdata     = '0;
        reg_rdata[15] = tout_q;
        reg_rdata[6]  = ie_q;
        reg_rdata[5]  = te_q;
        reg_rdata[4]  = nrsp_q;
        reg_rdata[0]  = crc_err_q;
      end
      6'h0C:   reg_rdata = {26'b0, idx_q};
      6'h10:   reg_rdata = arg_q;
      6'h14:   reg_rdata = rsp_q[0];
      6'h18:   reg_rdata = rsp_q[1];
      6'h1C:   reg_rdata = rsp_q[2];
      6'h20:   reg_rdata = rsp_q[3];
      6'h24:   reg_rdata = rsp_q[4];
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      en_q <= '0; ctl_q <= '0; arg_q <= '0; idx_q <= '0;
      for (int i = 0; i < 5; i++) rsp_q[i] <= '0;
      te_q <= 1'b0; ie_q <= 1'b0; crc_err_q <= 1'b0; nrsp_q <= 1'b0; tout_q <= 1'b0;
      pos_q <= '0; cnt_q <= '0; crc_q <= '0; sh_q <= '0; rx_q <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          6'h00: en_q <= reg_wdata;
          6'h04: if (!busy) ctl_q <= reg_wdata & ~32'h80;
          6'h08: begin
            ie_q <= reg_wdata[6];
            if (reg_wdata[5]) te_q <= 1'b0;
          end
          6'h0C: idx_q <= reg_wdata[5:0];
          6'h10: arg_q <= reg_wdata;
          default: ;
        endcase
      end

      if (start_ok) begin
        crc_err_q <= 1'b0; nrsp_q <= 1'b0; tout_q <= 1'b0;
        pos_q <= '0; cnt_q <= '0; crc_q <= '0; rx_q <= '0;
        sh_q  <= {2'b01, idx_q, arg_q};
        st_q  <= (reg_wdata[3:0] == 4'd8) ? S_INIT : S_TX;
      end

      case (st_q)
        S_TX: begin
          pos_q <= pos_q + 8'd1;
          if (pos_q < 8'd40) begin
            crc_q <= crc_step(crc_q, sh_q[39]);
            sh_q  <= {sh_q[38:0], 1'b0};
          end else begin
            crc_q <= {crc_q[5:0], 1'b0};
          end
          if (pos_q == 8'd47) begin
            if (mode == 4'd0) begin
              te_q <= 1'b1; st_q <= S_IDLE;
            end else begin
              st_q <= S_WAIT; cnt_q <= '0; crc_q <= '0;
            end
          end
        end
        S_WAIT: begin
          if (!cmd_in) begin
            st_q  <= S_RX;
            pos_q <= 8'd1;
            rx_q  <= rx_next;
            if (crc_feed) crc_q <= crc_step(crc_q, cmd_in);
          end else if (cnt_q == CNT_W'(RSP_WINDOW - 1)) begin
            nrsp_q <= 1'b1; te_q <= 1'b1; st_q <= S_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        S_RX: begin
          rx_q  <= rx_next;
          pos_q <= pos_q + 8'd1;
          if (crc_feed) crc_q <= crc_step(crc_q, cmd_in);
          if (pos_q == last_idx) begin
            crc_err_q <= (crc_q != rx_next[7:1]);
            rsp_q[0] <= rx_next[31:0];
            if (long_rsp) begin
              rsp_q[1] <= rx_next[63:32];
              rsp_q[2] <= rx_next[95:64];
              rsp_q[3] <= rx_next[127:96];
              rsp_q[4] <= {24'b0, rx_next[135:128]};
            end else begin
              rsp_q[1] <= {16'b0, rx_next[47:32]};
            end
            if (mode == 4'd3) begin
              st_q <= S_BUSY; cnt_q <= '0;
            end else begin
              te_q <= 1'b1; st_q <= S_IDLE;
            end
          end
        end
        S_BUSY: begin
          if (dat0_in) begin
            te_q <= 1'b1; st_q <= S_IDLE;
          end else if (ctl_q[31] && cnt_q == tout_lim) begin
            tout_q <= 1'b1; te_q <= 1'b1; st_q <= S_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        S_INIT: begin
          if (cnt_q + CNT_W'(1) >= init_lim) begin
            te_q <= 1'b1; st_q <= S_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sd_cmd_engine_chk.sv
`timescale 1ns/1ps
module sd_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_oe,
  input logic       cmd_out,
  input logic       sd_clk_en,
  input logic       te,
  input logic       busy,
  input logic       ctl_we,
  input logic [7:0] delay,
  input logic       crc_err,
  input logic       nrsp
);

  logic [6:0] oe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_run <= '0;
    else        oe_run <= cmd_oe ? oe_run + 7'd1 : 7'd0;
  end

  a_r2_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_out);

  a_r2_dir_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |=> cmd_out);

  a_r2_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_oe) |-> (oe_run == 7'd48));

  a_r10_clk_with_frame: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> sd_clk_en);

  a_r11_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(te) |-> $past(busy));

  a_r12_delay_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(delay));

  a_r6_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(crc_err && nrsp));

endmodule

bind sd_cmd_engine sd_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_oe(cmd_oe), .cmd_out(cmd_out),
  .sd_clk_en(sd_clk_en), .te(te_q), .busy(busy), .ctl_we(wr_ctl),
  .delay(ctl_q[23:16]), .crc_err(crc_err_q), .nrsp(nrsp_q)
);

// File: tb/test_sd_cmd_engine.sv
`timescale 1ns/1ps
module test_sd_cmd_engine;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, reg_we, cmd_out, cmd_oe, cmd_in, dat0_in, sd_clk_en, irq;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  sd_cmd_engine i_sd_cmd_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_out(cmd_out),
    .cmd_oe(cmd_oe), .cmd_in(cmd_in), .dat0_in(dat0_in),
    .sd_clk_en(sd_clk_en), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [6:0] crc7(input logic [127:0] v, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb;
      fb = c[6] ^ v[i];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] mkframe(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h = {2'b01, idx, arg};
    return {h, crc7(128'(h), 40), 1'b1};
  endfunction

  function automatic logic [135:0] mk48(input logic [5:0] idx, input logic [31:0] cs);
    logic [39:0] h = {2'b00, idx, cs};
    return 136'({h, crc7(128'(h), 40), 1'b1});
  endfunction

  function automatic logic [135:0] mk136(input logic [119:0] p);
    return {8'h3F, p, crc7(128'(p), 120), 1'b1};
  endfunction

  // card model
  logic [135:0] rsp_vec;
  int rsp_len = 48, rsp_dly = 2, busy_len = 0;
  bit rsp_on = 1'b0, card_busy = 1'b0;
  logic [47:0] cap;
  int frames = 0;

  initial begin
    cmd_in = 1'b1; dat0_in = 1'b1; cap = '0; rsp_vec = '0;
    forever begin
      @(negedge clk);
      if (cmd_oe) begin
        card_busy = 1'b1;
        for (int i = 0; i < 48; i++) begin
          cap = {cap[46:0], cmd_out};
          if (i < 47) @(negedge clk);
        end
        frames++;
        if (rsp_on) begin
          if (busy_len != 0) dat0_in = 1'b0;
          repeat (rsp_dly) @(negedge clk);
          for (int i = rsp_len - 1; i >= 0; i--) begin
            cmd_in = rsp_vec[i];
            @(negedge clk);
          end
          cmd_in = 1'b1;
          if (busy_len > 0) repeat (busy_len) @(negedge clk);
          else if (busy_len < 0) repeat (200) @(negedge clk);
          dat0_in = 1'b1;
        end
        card_busy = 1'b0;
      end
    end
  end

  int clk_cnt = 0, oe_cnt = 0;
  always @(negedge clk) begin
    if (sd_clk_en) clk_cnt++;
    if (cmd_oe) oe_cnt++;
  end

  // scoreboard
  typedef struct {
    string        req;
    logic [31:0]  st;
    int           kind;
    logic [135:0] rv;
    bit           cf;
    logic [47:0]  fr;
  } item_t;

  item_t sb[$];
  int done_cnt = 0;

  function automatic item_t mk_it(input string r, input logic [31:0] s, input int k,
                                  input logic [135:0] v, input bit c, input logic [47:0] f);
    item_t it;
    it.req = r; it.st = s; it.kind = k; it.rv = v; it.cf = c; it.fr = f;
    return it;
  endfunction

  initial begin
    forever begin
      item_t it;
      logic [31:0] d, b0, b1, b2, b3, b4;
      @(posedge irq);
      @(negedge clk);
      if (sb.size() == 0) begin
        chk("R11 irq without pending operation", 64'd1, 64'd0);
      end else begin
        it = sb.pop_front();
        chk({it.req, " irq level"}, 64'(irq), 64'd1);
        rd(6'h08, d);
        chk({it.req, " status"}, 64'(d), 64'(it.st));
        if (it.kind == 1) begin
          rd(6'h14, b0); rd(6'h18, b1);
          chk({it.req, " word0"}, 64'(b0), 64'(it.rv[31:0]));
          chk({it.req, " word1"}, 64'(b1), 64'({16'b0, it.rv[47:32]}));
          chk({it.req, " card status"}, 64'({b1[7:0], b0[31:8]}), 64'(it.rv[39:8]));
        end else if (it.kind == 2) begin
          rd(6'h14, b0); rd(6'h18, b1); rd(6'h1C, b2); rd(6'h20, b3); rd(6'h24, b4);
          chk({it.req, " word0"}, 64'(b0), 64'(it.rv[31:0]));
          chk({it.req, " word1"}, 64'(b1), 64'(it.rv[63:32]));
          chk({it.req, " word2"}, 64'(b2), 64'(it.rv[95:64]));
          chk({it.req, " word3"}, 64'(b3), 64'(it.rv[127:96]));
          chk({it.req, " word4"}, 64'(b4), 64'({24'b0, it.rv[135:128]}));
        end
        if (it.cf) chk("R2 frame bits", 64'(cap), 64'(it.fr));
      end
      wr(6'h08, 32'h60);
      done_cnt++;
    end
  end

  task automatic issue(input item_t it, input logic [31:0] ctlw);
    int d0 = done_cnt;
    sb.push_back(it);
    wr(6'h04, ctlw);
    wait (done_cnt != d0);
    wait (!card_busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [135:0] v;
    int c0, o0, f0, dn;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset and storage
    rd(6'h08, d); chk("R1 status after reset", 64'(d), 64'h0);
    rd(6'h04, d); chk("R1 control after reset", 64'(d), 64'h0);
    rd(6'h14, d); chk("R1 word0 after reset", 64'(d), 64'h0);
    chk("R1 irq after reset", 64'(irq), 64'h0);
    chk("R1 cmd_oe after reset", 64'(cmd_oe), 64'h0);
    wr(6'h00, 32'h8000_0480); rd(6'h00, d); chk("R1 enable readback", 64'(d), 64'h8000_0480);
    wr(6'h0C, 32'h0000_002A); rd(6'h0C, d); chk("R1 index readback", 64'(d), 64'h2A);
    wr(6'h10, 32'hDEAD_BEEF); rd(6'h10, d); chk("R1 argument readback", 64'(d), 64'hDEAD_BEEF);

    wr(6'h08, 32'h40);

    // R3 no reply, R2 frame
    wr(6'h0C, 32'h0); wr(6'h10, 32'h0);
    rsp_on = 1'b0;
    issue(mk_it("R3", 32'h60, 0, '0, 1'b1, mkframe(6'd0, 32'h0)), 32'h80);

    // R4 short replies, codes 1, 4, 5
    rsp_on = 1'b1; rsp_len = 48; rsp_dly = 2; busy_len = 0;
    wr(6'h0C, 32'd17); wr(6'h10, 32'h1234_5678);
    rsp_vec = mk48(6'd17, 32'h0000_0900);
    issue(mk_it("R4 code1", 32'h60, 1, rsp_vec, 1'b1, mkframe(6'd17, 32'h1234_5678)), 32'h81);
    wr(6'h0C, 32'd18); wr(6'h10, 32'h0000_0200);
    rsp_vec = mk48(6'd18, 32'hA5C3_0B00); rsp_dly = 7;
    issue(mk_it("R4 code4", 32'h60, 1, rsp_vec, 1'b1, mkframe(6'd18, 32'h0000_0200)), 32'h84);
    wr(6'h0C, 32'd25); wr(6'h10, 32'hFFFF_FFFF);
    rsp_vec = mk48(6'd25, 32'h5A5A_0D00); rsp_dly = 1;
    issue(mk_it("R4 code5", 32'h60, 1, rsp_vec, 1'b1, mkframe(6'd25, 32'hFFFF_FFFF)), 32'h85);

    // R5 long reply
    wr(6'h0C, 32'd2); wr(6'h10, 32'h0);
    rsp_len = 136; rsp_dly = 5;
    rsp_vec = mk136(120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32);
    issue(mk_it("R5", 32'h60, 2, rsp_vec, 1'b1, mkframe(6'd2, 32'h0)), 32'h82);

    // R6 checksum error
    rsp_len = 48; rsp_dly = 3;
    wr(6'h0C, 32'd13); wr(6'h10, 32'h0001_0000);
    rsp_vec = mk48(6'd13, 32'h0000_0B00) ^ 136'h2;
    issue(mk_it("R6", 32'h61, 1, rsp_vec, 1'b0, '0), 32'h81);

    // R7 reply window
    rsp_on = 1'b0;
    issue(mk_it("R7 silent card", 32'h70, 0, '0, 1'b0, '0), 32'h81);
    rsp_on = 1'b1; rsp_dly = 63;
    rsp_vec = mk48(6'd13, 32'h0000_0700);
    issue(mk_it("R7 reply inside window", 32'h60, 1, rsp_vec, 1'b0, '0), 32'h81);
    rsp_dly = 66;
    issue(mk_it("R7 reply after window", 32'h70, 0, '0, 1'b0, '0), 32'h81);

    // R8 busy wait, R9 timeout
    rsp_dly = 2; busy_len = 20;
    wr(6'h0C, 32'd7);
    rsp_vec = mk48(6'd7, 32'h0000_0800);
    issue(mk_it("R8", 32'h60, 1, rsp_vec, 1'b0, '0), 32'h83);
    busy_len = -1;
    issue(mk_it("R9 timeout", 32'h8060, 1, rsp_vec, 1'b0, '0), 32'h8200_0083);
    busy_len = 0;
    issue(mk_it("R9 flags cleared on next start", 32'h60, 1, rsp_vec, 1'b0, '0), 32'h81);

    // R10 power-up clocks
    c0 = clk_cnt; o0 = oe_cnt;
    issue(mk_it("R10", 32'h60, 0, '0, 1'b0, '0), 32'h0588);
    chk("R10 clock cycles", 64'(clk_cnt - c0), 64'd80);
    chk("R10 line not driven", 64'(oe_cnt - o0), 64'd0);

    // R13 illegal code
    c0 = clk_cnt;
    wr(6'h04, 32'h86);
    repeat (20) @(negedge clk);
    chk("R13 no clock", 64'(clk_cnt - c0), 64'd0);
    rd(6'h08, d); chk("R13 no done flag", 64'(d), 64'h40);
    rd(6'h04, d); chk("R13 not running", 64'(d), 64'h06);

    // R11 write-one-to-clear with interrupt disabled
    wr(6'h08, 32'h0);
    rsp_on = 1'b0;
    wr(6'h04, 32'h80);
    repeat (60) @(negedge clk);
    chk("R11 irq masked", 64'(irq), 64'd0);
    rd(6'h08, d); chk("R11 done flag set", 64'(d), 64'h20);
    wr(6'h08, 32'h0);
    rd(6'h08, d); chk("R11 write 0 keeps flag", 64'(d), 64'h20);
    wr(6'h08, 32'h20);
    rd(6'h08, d); chk("R11 write 1 clears flag", 64'(d), 64'h0);
    wr(6'h08, 32'h40);

    // R12 delay field kept, writes while running ignored
    rsp_on = 1'b1; rsp_dly = 10; busy_len = 0;
    rsp_vec = mk48(6'd7, 32'h0000_0900);
    f0 = frames; dn = done_cnt;
    sb.push_back(mk_it("R12", 32'h60, 1, rsp_vec, 1'b0, '0));
    wr(6'h04, 32'h00A5_0081);
    rd(6'h04, d); chk("R12 running readback", 64'(d), 64'h00A5_0081);
    wr(6'h04, 32'h0000_0080);
    rd(6'h04, d); chk("R12 write while running ignored", 64'(d), 64'h00A5_0081);
    wait (done_cnt != dn);
    wait (!card_busy);
    repeat (2) @(negedge clk);
    rd(6'h04, d); chk("R12 delay kept after operation", 64'(d), 64'h00A5_0001);
    chk("R12 single frame", 64'(frames - f0), 64'd1);

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end

endmodule